// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds two 32-bit operands as a set of independent packed lanes. A two-bit lane-width control splits the operands into four 8-bit lanes, two 16-bit lanes or a single 32-bit lane. Carries are cut at every lane edge, so each lane behaves as a separate adder. A two-bit mode control makes every lane either wrap modulo its width, clamp to all ones on an unsigned carry out, or clamp to the largest positive or most negative two's-complement value on a signed overflow.

The block is purely combinational and is meant to sit inside a datapath that registers its result. Next to the sum it returns one overflow bit per byte position. Each byte of a lane carries that lane's flag, so downstream logic can read the flags at byte granularity whatever the lane width. In the saturating modes the flag follows the kind of overflow being clamped. In wrap mode a separate select bit chooses whether the flag shows the unsigned carry or the signed overflow.

Top module: `simd_sat_add`

## Requirements
- R1: `lane_w_i` selects the lane size: 00 gives four 8-bit lanes, 01 gives two 16-bit lanes, 10 and 11 both give one 32-bit lane. Lane k of byte size covers bits [8k+7:8k]. No carry passes from one lane into the next.
- R2: With `mode_i` 00 (wrap), and also with the spare code 11, each lane returns its operand sum modulo 2^W, where W is the lane width (FFh+01h=00h, 7Fh+01h=80h for byte lanes).
- R3: With `mode_i` 01 (unsigned saturate), a lane whose addition carries out of its top bit returns all ones (FFh+01h=FFh).
- R4: With `mode_i` 10 (signed saturate), a lane overflows when both operands have the same sign bit and the sum's sign bit differs. It then returns that sign followed by the inverted sign in all lower bits (7Fh positive, 80h negative for 8 bits; 7FFFh/8000h for 16 bits).
- R5: In signed saturate mode, a lane whose operands have different sign bits never overflows and returns its plain sum.
- R6: `ovf_o` has one bit per byte. Bit i belongs to sum bits [8i+7:8i], and every byte of a lane shows the same flag as the whole lane.
- R7: In unsigned saturate mode the lane flag is the carry out of the lane. In signed saturate mode it is the signed overflow of R4.
- R8: In wrap mode (00 or 11) the lane flag is the unsigned carry out when `flag_signed_i` is 0 and the signed overflow when it is 1. The sum is wrapped in either case.
- R9: In either saturating mode, a lane without overflow returns exactly its wrapped sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| lane_w_i | input | 2 | Lane size: 00 byte, 01 halfword, 10/11 word |
| mode_i | input | 2 | 00 wrap, 01 unsigned saturate, 10 signed saturate, 11 wrap |
| flag_signed_i | input | 1 | Flag kind in wrap mode: 0 carry, 1 signed overflow |
| sum_o | output | 32 | Packed lane results |
| ovf_o | output | 4 | Per-byte lane overflow flags |

## Verification
The assertions check the following whenever the inputs change:
- A flagged lane in unsigned mode is all ones.
- A flagged top lane in signed mode holds one of the two clamp patterns.
- Byte lanes with mixed operand signs never flag in signed mode.
- Flags are uniform across the bytes of a 16-bit or 32-bit lane.
- An unflagged or wrapping byte lane equals its modular sum.

The bench scenarios cover what those properties cannot show without a reference model:
- Carries cut exactly at the lane edges for each width.
- The correct clamp value in the lower bytes of wide lanes.
- The spare lane and mode codes.
- Which flag kind the wrap-mode select bit picks.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  // lane size control
  typedef enum logic [1:0] {
    LW_BYTE = 2'b00,
    LW_HALF = 2'b01,
    LW_WORD = 2'b10,
    LW_SPARE = 2'b11
  } lane_w_e;

  // per-lane arithmetic behaviour
  typedef enum logic [1:0] {
    MD_WRAP  = 2'b00,
    MD_USAT  = 2'b01,
    MD_SSAT  = 2'b10,
    MD_SPARE = 2'b11
  } sat_mode_e;
endpackage

// File: rtl/simd_lane_map.sv
// Maps the lane size code to per-byte lane geometry: which byte starts a
// lane, which byte is the top of its lane, and the top byte index of each.
module simd_lane_map #(
  parameter int NB   = 4,
  localparam int IDXW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [1:0]                 lane_w_i,
  output logic [NB-1:0]              start_o,
  output logic [NB-1:0]              top_o,
  output logic [NB-1:0][IDXW-1:0]    top_idx_o
);
  import simd_sat_pkg::*;

  lane_w_e lw;
  assign lw = lane_w_e'(lane_w_i);

  for (genvar i = 0; i < NB; i++) begin : g_map
    always_comb begin
      unique case (lw)
        LW_BYTE: top_idx_o[i] = IDXW'(i);
        LW_HALF: top_idx_o[i] = IDXW'(i | 1);
        default: top_idx_o[i] = IDXW'(NB - 1);
      endcase
    end

    assign top_o[i] = (top_idx_o[i] == IDXW'(i));

    if (i == 0) begin : g_first
      assign start_o[i] = 1'b1;
    end else begin : g_rest
      assign start_o[i] = top_o[i-1];
    end
  end
endmodule

// File: rtl/simd_byte_add.sv
// One byte slice of the segmented carry chain.
module simd_byte_add #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  input  logic          cin_i,
  output logic [BW-1:0] sum_o,
  output logic          cout_o
);
  logic [BW:0] full;

  always_comb begin
    full   = {1'b0, a_i} + {1'b0, b_i} + {{BW{1'b0}}, cin_i};
    sum_o  = full[BW-1:0];
    cout_o = full[BW];
  end
endmodule

// File: rtl/simd_byte_sel.sv
// Picks the final value and flag of one byte from its lane's overflow status.
module simd_byte_sel #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] raw_i,
  input  logic [1:0]    mode_i,
  input  logic          flag_signed_i,
  input  logic          is_top_i,
  input  logic          lane_sign_i,
  input  logic          lane_carry_i,
  input  logic          lane_sov_i,
  output logic [BW-1:0] res_o,
  output logic          flag_o
);
  import simd_sat_pkg::*;

  sat_mode_e     md;
  logic [BW-1:0] sclamp;

  assign md = sat_mode_e'(mode_i);

  // the top byte carries the sign, lower bytes are filled with its inverse
  always_comb begin
    if (is_top_i) sclamp = {lane_sign_i, {(BW-1){~lane_sign_i}}};
    else          sclamp = {BW{~lane_sign_i}};
  end

  always_comb begin
    unique case (md)
      MD_USAT: flag_o = lane_carry_i;
      MD_SSAT: flag_o = lane_sov_i;
      default: flag_o = flag_signed_i ? lane_sov_i : lane_carry_i;
    endcase
  end

  always_comb begin
    res_o = raw_i;
    if (md == MD_USAT && lane_carry_i)     res_o = {BW{1'b1}};
    else if (md == MD_SSAT && lane_sov_i)  res_o = sclamp;
  end
endmodule

// File: rtl/simd_sat_add.sv
// Packed SIMD adder with per-lane wrap, unsigned or signed saturation.
module simd_sat_add #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  input  logic [1:0]               lane_w_i,
  input  logic [1:0]               mode_i,
  input  logic                     flag_signed_i,
  output logic [DATA_W-1:0]        sum_o,
  output logic [DATA_W/BYTE_W-1:0] ovf_o
);
  localparam int NB   = DATA_W / BYTE_W;
  localparam int IDXW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0]           start_b, top_b;
  logic [NB-1:0][IDXW-1:0] top_idx;
  logic [NB-1:0]           cin_b, cout_b;
  logic [NB-1:0]           a_msb, b_msb, t_msb, sov_b;
  logic [DATA_W-1:0]       raw;

  simd_lane_map #(.NB(NB)) u_map (
    .lane_w_i  (lane_w_i),
    .start_o   (start_b),
    .top_o     (top_b),
    .top_idx_o (top_idx)
  );

  for (genvar i = 0; i < NB; i++) begin : g_byte
    if (i == 0) begin : g_c0
      assign cin_b[i] = 1'b0;
    end else begin : g_cn
      assign cin_b[i] = start_b[i] ? 1'b0 : cout_b[i-1];
    end

    simd_byte_add #(.BW(BYTE_W)) u_add (
      .a_i    (a_i[i*BYTE_W +: BYTE_W]),
      .b_i    (b_i[i*BYTE_W +: BYTE_W]),
      .cin_i  (cin_b[i]),
      .sum_o  (raw[i*BYTE_W +: BYTE_W]),
      .cout_o (cout_b[i])
    );

    // signed overflow as seen if this byte were the top of its lane
    assign a_msb[i] = a_i[i*BYTE_W + BYTE_W - 1];
    assign b_msb[i] = b_i[i*BYTE_W + BYTE_W - 1];
    assign t_msb[i] = raw[i*BYTE_W + BYTE_W - 1];
    assign sov_b[i] = (t_msb[i] & ~a_msb[i] & ~b_msb[i]) |
                      (~t_msb[i] & a_msb[i] & b_msb[i]);

    simd_byte_sel #(.BW(BYTE_W)) u_sel (
      .raw_i         (raw[i*BYTE_W +: BYTE_W]),
      .mode_i        (mode_i),
      .flag_signed_i (flag_signed_i),
      .is_top_i      (top_b[i]),
      .lane_sign_i   (a_msb[top_idx[i]]),
      .lane_carry_i  (cout_b[top_idx[i]]),
      .lane_sov_i    (sov_b[top_idx[i]]),
      .res_o         (sum_o[i*BYTE_W +: BYTE_W]),
      .flag_o        (ovf_o[i])
    );
  end
endmodule

// File: rtl/simd_sat_add_chk.sv
// Property checker for simd_sat_add, attached through bind.
module simd_sat_add_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic [DATA_W-1:0]        a_i,
  input logic [DATA_W-1:0]        b_i,
  input logic [1:0]               lane_w_i,
  input logic [1:0]               mode_i,
  input logic                     flag_signed_i,
  input logic [DATA_W-1:0]        sum_o,
  input logic [DATA_W/BYTE_W-1:0] ovf_o
);
  localparam int NB = DATA_W / BYTE_W;
  localparam logic [BYTE_W-1:0] POS_CAP = {1'b0, {(BYTE_W-1){1'b1}}};
  localparam logic [BYTE_W-1:0] NEG_CAP = {1'b1, {(BYTE_W-1){1'b0}}};

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      if (mode_i == 2'b01 && ovf_o[i])
        assert_ucap_all_ones_R3: assert (sum_o[i*BYTE_W +: BYTE_W] == {BYTE_W{1'b1}})
          else $error("R3: unsigned clamp byte %0d not all ones", i);

      if (mode_i == 2'b10 && lane_w_i == 2'b00 &&
          a_i[i*BYTE_W+BYTE_W-1] != b_i[i*BYTE_W+BYTE_W-1])
        assert_no_overflow_R5: assert (!ovf_o[i])
          else $error("R5: mixed-sign byte lane %0d flagged", i);

      if (lane_w_i == 2'b00 && (mode_i[0] == mode_i[1] || !ovf_o[i]))
        assert_plain_sum_R9: assert (sum_o[i*BYTE_W +: BYTE_W] ==
            BYTE_W'(a_i[i*BYTE_W +: BYTE_W] + b_i[i*BYTE_W +: BYTE_W]))
          else $error("R9: byte lane %0d differs from modular sum", i);
    end

    if (mode_i == 2'b10 && ovf_o[NB-1])
      assert_scap_pattern_R4: assert (sum_o[DATA_W-1 -: BYTE_W] == POS_CAP ||
                                       sum_o[DATA_W-1 -: BYTE_W] == NEG_CAP)
        else $error("R4: signed clamp top byte malformed");

    if (lane_w_i == 2'b01)
      for (int k = 0; k < NB/2; k++)
        assert_half_flags_R6: assert (ovf_o[2*k] == ovf_o[2*k+1])
          else $error("R6: halfword lane %0d flags differ", k);

    if (lane_w_i[1])
      assert_word_flags_R6: assert ($countones(ovf_o) == 0 || $countones(ovf_o) == NB)
        else $error("R6: word lane flags not uniform");
  end
endmodule

bind simd_sat_add simd_sat_add_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .a_i           (a_i),
  .b_i           (b_i),
  .lane_w_i      (lane_w_i),
  .mode_i        (mode_i),
  .flag_signed_i (flag_signed_i),
  .sum_o         (sum_o),
  .ovf_o         (ovf_o)
);

// File: tb/tb_simd_sat_add.sv
module tb_simd_sat_add;
  logic        clk;
  logic        rst_n;
  logic [31:0] a, b, sum;
  logic [1:0]  lw, md;
  logic        fs;
  logic [3:0]  ovf;

  int checks;
  int errors;
  bit done;

  simd_sat_add dut (
    .a_i (a), .b_i (b), .lane_w_i (lw), .mode_i (md),
    .flag_signed_i (fs), .sum_o (sum), .ovf_o (ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 50000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  // reference from the requirement text: lanes of 1, 2 or 4 bytes
  function automatic void model(input logic [31:0] ma, input logic [31:0] mb,
                                input logic [1:0] mlw, input logic [1:0] mmd,
                                input logic mfs, output logic [31:0] rs,
                                output logic [3:0] rf);
    int nby;
    logic [63:0] mask, ua, ub, us, val;
    logic cy, sa, sb, st, sv, fl;
    nby = (mlw == 2'b00) ? 1 : (mlw == 2'b01) ? 2 : 4;
    rs = '0;
    rf = '0;
    for (int k = 0; k < 4; k += nby) begin
      mask = (64'd1 << (8*nby)) - 64'd1;
      ua = ({32'd0, ma} >> (8*k)) & mask;
      ub = ({32'd0, mb} >> (8*k)) & mask;
      us = ua + ub;
      cy = us[8*nby];
      sa = ua[8*nby-1];
      sb = ub[8*nby-1];
      st = us[8*nby-1];
      sv = (sa == sb) && (st != sa);
      val = us & mask;
      if (mmd == 2'b01) begin
        fl = cy;
        if (cy) val = mask;
      end else if (mmd == 2'b10) begin
        fl = sv;
        if (sv) val = sa ? (64'd1 << (8*nby-1)) : (mask >> 1);
      end else begin
        fl = mfs ? sv : cy;
      end
      rs = rs | 32'(val << (8*k));
      for (int j = k; j < k + nby; j++) rf[j] = fl;
    end
  endfunction

  task automatic drive(input logic [31:0] ta, input logic [31:0] tb_,
                       input logic [1:0] tlw, input logic [1:0] tmd, input logic tfs);
    @(negedge clk);
    a = ta; b = tb_; lw = tlw; md = tmd; fs = tfs;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] es, input logic [3:0] ef);
    checks++;
    if (sum !== es || ovf !== ef) begin
      errors++;
      $display("FAIL %s: a=%h b=%h lw=%b md=%b fs=%b sum=%h ovf=%b expected sum=%h ovf=%b",
               req, a, b, lw, md, fs, sum, ovf, es, ef);
    end
  endtask

  // literal expectation plus model cross-check
  task automatic vec(input string req, input logic [31:0] ta, input logic [31:0] tb_,
                     input logic [1:0] tlw, input logic [1:0] tmd, input logic tfs,
                     input logic [31:0] es, input logic [3:0] ef);
    logic [31:0] ms;
    logic [3:0] mf;
    drive(ta, tb_, tlw, tmd, tfs);
    check(req, es, ef);
    model(ta, tb_, tlw, tmd, tfs, ms, mf);
    check({req, " model"}, ms, mf);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R2 reset zero inputs", 32'h0, 4'h0);
  endtask

  task automatic t_wrap_r2_r8();
    vec("R2 R8 wrap FF+01 carry flag", 32'h000000FF, 32'h00000001, 2'b00, 2'b00, 1'b0, 32'h00000000, 4'b0001);
    vec("R2 R8 wrap 7F+01 signed flag", 32'h0000007F, 32'h00000001, 2'b00, 2'b00, 1'b1, 32'h00000080, 4'b0001);
    vec("R8 wrap 7F+01 carry flag clear", 32'h0000007F, 32'h00000001, 2'b00, 2'b00, 1'b0, 32'h00000080, 4'b0000);
    vec("R2 spare mode 11 wraps", 32'hFF0000FF, 32'h01000001, 2'b00, 2'b11, 1'b0, 32'h00000000, 4'b1001);
  endtask

  task automatic t_usat_r3();
    vec("R3 R7 usat byte lanes", 32'hFF7F0180, 32'h01010101, 2'b00, 2'b01, 1'b0, 32'hFF800281, 4'b1000);
    vec("R3 R6 usat half lanes", 32'hFFFF1234, 32'h00010001, 2'b01, 2'b01, 1'b0, 32'hFFFF1235, 4'b1100);
    vec("R3 usat word lane", 32'hFFFFFFFF, 32'h00000002, 2'b10, 2'b01, 1'b0, 32'hFFFFFFFF, 4'b1111);
  endtask

  task automatic t_ssat_r4_r5();
    vec("R4 R5 ssat byte lanes", 32'h7F804010, 32'h0180C020, 2'b00, 2'b10, 1'b0, 32'h7F800030, 4'b1100);
    vec("R4 R6 ssat half lanes", 32'h7FFF8000, 32'h0001FFFF, 2'b01, 2'b10, 1'b0, 32'h7FFF8000, 4'b1111);
    vec("R4 ssat word lane", 32'h7FFFFFFF, 32'h00000001, 2'b10, 2'b10, 1'b0, 32'h7FFFFFFF, 4'b1111);
    vec("R5 ssat mixed signs half", 32'h7FFF8000, 32'h80007FFF, 2'b01, 2'b10, 1'b0, 32'hFFFFFFFF, 4'b0000);
  endtask

  task automatic t_lanes_r1();
    vec("R1 byte lanes cut carry", 32'h0000FFFF, 32'h00000001, 2'b00, 2'b00, 1'b0, 32'h0000FF00, 4'b0001);
    vec("R1 half lanes pass carry inside", 32'h0000FFFF, 32'h00000001, 2'b01, 2'b00, 1'b0, 32'h00000000, 4'b0011);
    vec("R1 half lanes cut at bit 16", 32'hFFFFFFFF, 32'h00000001, 2'b01, 2'b00, 1'b0, 32'hFFFF0000, 4'b0011);
    vec("R1 spare width 11 is word", 32'h80000000, 32'h80000000, 2'b11, 2'b00, 1'b1, 32'h00000000, 4'b1111);
  endtask

  task automatic t_no_ovf_r9();
    vec("R9 usat no overflow", 32'h10203040, 32'h01020304, 2'b00, 2'b01, 1'b0, 32'h11223344, 4'b0000);
    vec("R9 ssat no overflow", 32'h3FFFC000, 32'h00010001, 2'b01, 2'b10, 1'b0, 32'h4000C001, 4'b0000);
  endtask

  task automatic t_sweep_r7();
    logic [31:0] ms;
    logic [3:0] mf;
    for (int n = 0; n < 400; n++) begin
      drive($urandom, $urandom, 2'($urandom), 2'($urandom), 1'($urandom));
      model(a, b, lw, md, fs, ms, mf);
      check("R7 R6 sweep vs reference", ms, mf);
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    a = '0; b = '0; lw = '0; md = '0; fs = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wrap_r2_r8();
    t_usat_r3();
    t_ssat_r4_r5();
    t_lanes_r1();
    t_no_ovf_r9();
    t_sweep_r7();
    report();
  end
endmodule